// File: doc/BRIEF.md
# Supervisor Trap Vector Address Unit

This block holds the supervisor trap-vector configuration register and turns it into the program counter that the core jumps to when a trap is taken. The register has two fields. A base address fills bits XLEN-1:2, so the base is always 4-byte aligned. A two-bit mode fills bits 1:0. Software reads and writes the register through a simple CSR port. Each write is legalized before it is stored: a reserved mode value is refused, and vectored mode imposes a stricter alignment on the base.

When the pipeline asserts the trap strobe, the block looks at the stored configuration, the interrupt flag and the cause code, and drives the jump target combinationally in that same cycle. In direct mode every trap goes to the base. In vectored mode only asynchronous interrupts are spread over a table of 4-byte slots indexed by cause. Synchronous exceptions still land on the unscaled base.

Top module: `trap_vec_unit`

## Requirements
- R1: After the active-low asynchronous reset, csr_rdata_o reads 0: base 0, mode direct (encoding 0).
- R2: A write with csr_we_i high and a legal mode (bits 1:0 equal to 0 for direct or 1 for vectored) takes effect at the next rising clock edge. csr_rdata_o then returns {wdata[XLEN-1:2], wdata[1:0]}, subject to R4.
- R3: A write whose bits 1:0 hold 2 or 3 (reserved) leaves the stored mode unchanged. The base field is still written and is aligned according to the retained mode.
- R4: Whenever the stored mode is vectored, address bits VEC_ALIGN_BITS-1:2 of the base (bits 5:2 by default, giving 64-byte alignment) are zero, because they are cleared on the write.
- R5: In direct mode, trap_pc_o equals the base address for every trap, exception or interrupt.
- R6: In vectored mode, a trap with trap_irq_i low (synchronous exception) gives trap_pc_o equal to the base, whatever the cause.
- R7: In vectored mode, a trap with trap_irq_i high gives trap_pc_o = base + 4 × trap_cause_i. The timer interrupt, cause 5, therefore lands at base + 0x14.
- R8: trap_pc_o and trap_pc_valid_o are combinational from the stored register and the trap inputs. trap_pc_valid_o equals trap_i in the same cycle. A write in the same cycle as a trap does not affect that trap's target.
- R9: With csr_we_i low, the stored register does not change, whatever csr_wdata_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Stored, legalized base and mode |
| trap_i | input | 1 | Trap-taken strobe |
| trap_irq_i | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| trap_cause_i | input | CAUSE_W | Trap cause code |
| trap_pc_o | output | XLEN | Trap target program counter |
| trap_pc_valid_o | output | 1 | Target valid, equal to trap_i |

## Verification
The bench writes reserved mode values 2 and 3 from both direct and vectored state. A design that stored them, or that fell back to direct, would read back the wrong mode bits; one that aligned the base for the written mode rather than the retained one would read back the wrong base. Vectored writes with the low base bits set expose a missing 64-byte clear. Exceptions in vectored mode and the timer cause 5 catch a target that scales exceptions or uses the wrong slot size. The largest cause code catches a truncated offset. A write issued in the same cycle as a trap catches a target that looks through to the incoming write data instead of the stored value.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_VECTORED = 2'd1
  } tvec_mode_e;

  function automatic logic mode_is_legal(input logic [1:0] m);
    return (m == MODE_DIRECT) || (m == MODE_VECTORED);
  endfunction
endpackage

// File: rtl/trap_vec_legalize.sv
module trap_vec_legalize
  import trap_vec_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter int VEC_ALIGN_BITS = 6
) (
  input  logic [XLEN-1:0] wdata_i,
  input  tvec_mode_e      cur_mode_i,
  output logic [XLEN-3:0] nxt_base_o,
  output tvec_mode_e      nxt_mode_o
);
  localparam int CLR_W = VEC_ALIGN_BITS - 2;

  always_comb begin
    // WARL: reserved encodings keep the current mode
    nxt_mode_o = mode_is_legal(wdata_i[1:0]) ? tvec_mode_e'(wdata_i[1:0]) : cur_mode_i;
    nxt_base_o = wdata_i[XLEN-1:2];
    if (nxt_mode_o == MODE_VECTORED) nxt_base_o[CLR_W-1:0] = '0;
  end
endmodule

// File: rtl/trap_vec_reg.sv
module trap_vec_reg
  import trap_vec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-3:0] nxt_base_i,
  input  tvec_mode_e      nxt_mode_i,
  output logic [XLEN-3:0] base_o,
  output tvec_mode_e      mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mode_o <= MODE_DIRECT;
    end else if (we_i) begin
      base_o <= nxt_base_i;
      mode_o <= nxt_mode_i;
    end
  end
endmodule

// File: rtl/trap_vec_target.sv
module trap_vec_target
  import trap_vec_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-3:0]    base_i,
  input  tvec_mode_e         mode_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  localparam int PAD_W = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] base_addr;
  logic [XLEN-1:0] slot_off;

  assign base_addr = {base_i, 2'b00};
  assign slot_off  = {{PAD_W{1'b0}}, cause_i, 2'b00};

  always_comb begin
    pc_o = base_addr;
    if (mode_i == MODE_VECTORED && irq_i) pc_o = base_addr + slot_off;
  end
endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
  import trap_vec_pkg::*;
#(
  parameter int XLEN           = 32,
  parameter int CAUSE_W        = 6,
  parameter int VEC_ALIGN_BITS = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic               trap_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  output logic [XLEN-1:0]    trap_pc_o,
  output logic               trap_pc_valid_o
);
  logic [XLEN-3:0] nxt_base, cur_base;
  tvec_mode_e      nxt_mode, cur_mode;

  trap_vec_legalize #(.XLEN(XLEN), .VEC_ALIGN_BITS(VEC_ALIGN_BITS)) u_legal (
    .wdata_i    (csr_wdata_i),
    .cur_mode_i (cur_mode),
    .nxt_base_o (nxt_base),
    .nxt_mode_o (nxt_mode)
  );

  trap_vec_reg #(.XLEN(XLEN)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (csr_we_i),
    .nxt_base_i (nxt_base),
    .nxt_mode_i (nxt_mode),
    .base_o     (cur_base),
    .mode_o     (cur_mode)
  );

  trap_vec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tgt (
    .base_i  (cur_base),
    .mode_i  (cur_mode),
    .irq_i   (trap_irq_i),
    .cause_i (trap_cause_i),
    .pc_o    (trap_pc_o)
  );

  assign csr_rdata_o     = {cur_base, cur_mode};
  assign trap_pc_valid_o = trap_i;
endmodule

// File: rtl/trap_vec_unit_chk.sv
module trap_vec_unit_chk #(
  parameter int XLEN           = 32,
  parameter int CAUSE_W        = 6,
  parameter int VEC_ALIGN_BITS = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csr_we_i,
  input logic [XLEN-1:0]    csr_wdata_i,
  input logic [XLEN-1:0]    csr_rdata_o,
  input logic               trap_i,
  input logic               trap_irq_i,
  input logic [CAUSE_W-1:0] trap_cause_i,
  input logic [XLEN-1:0]    trap_pc_o,
  input logic               trap_pc_valid_o
);
  logic [XLEN-1:0] base_addr;
  assign base_addr = {csr_rdata_o[XLEN-1:2], 2'b00};

  a_r3_reserved_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[1]) |=> (csr_rdata_o[1:0] == $past(csr_rdata_o[1:0])));

  a_r3_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[1] == 1'b0);

  a_r4_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o[1:0] == 2'd1) |-> (csr_rdata_o[VEC_ALIGN_BITS-1:2] == '0));

  a_r5_direct_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && csr_rdata_o[1:0] == 2'd0) |-> (trap_pc_o == base_addr));

  a_r6_vec_exc_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && !trap_irq_i && csr_rdata_o[1:0] == 2'd1) |-> (trap_pc_o == base_addr));

  a_r7_vec_irq_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && trap_irq_i && csr_rdata_o[1:0] == 2'd1) |-> (trap_pc_o[1:0] == 2'b00 && trap_pc_o >= base_addr));

  a_r8_valid_follows_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pc_valid_o == trap_i);

  a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> $stable(csr_rdata_o));
endmodule

bind trap_vec_unit trap_vec_unit_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_ALIGN_BITS(VEC_ALIGN_BITS)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .csr_we_i        (csr_we_i),
  .csr_wdata_i     (csr_wdata_i),
  .csr_rdata_o     (csr_rdata_o),
  .trap_i          (trap_i),
  .trap_irq_i      (trap_irq_i),
  .trap_cause_i    (trap_cause_i),
  .trap_pc_o       (trap_pc_o),
  .trap_pc_valid_o (trap_pc_valid_o)
);

// File: tb/trap_vec_unit_test.sv
`timescale 1ns/1ps
module trap_vec_unit_test;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            csr_we = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            trap = 1'b0;
  logic            trap_irq = 1'b0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] trap_pc;
  logic            trap_pc_valid;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  trap_vec_unit #(.XLEN(XLEN), .CAUSE_W(CW), .VEC_ALIGN_BITS(6)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata), .trap_i(trap), .trap_irq_i(trap_irq),
    .trap_cause_i(trap_cause), .trap_pc_o(trap_pc), .trap_pc_valid_o(trap_pc_valid)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [XLEN-1:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap_check(input string req, input logic irq, input logic [CW-1:0] c,
                            input logic [XLEN-1:0] exp);
    @(negedge clk);
    trap = 1'b1; trap_irq = irq; trap_cause = c;
    #1;
    check(req, trap_pc, exp);
    check("R8 valid", {31'd0, trap_pc_valid}, 32'd1);
    @(negedge clk);
    trap = 1'b0;
    #1;
    check("R8 valid low", {31'd0, trap_pc_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset", csr_rdata, 32'h0);
  endtask

  task automatic t_direct;
    csr_write(32'h1000_0F3C);
    check("R2 direct readback", csr_rdata, 32'h1000_0F3C);
    trap_check("R5 direct exc", 1'b0, 6'd2, 32'h1000_0F3C);
    trap_check("R5 direct irq", 1'b1, 6'd5, 32'h1000_0F3C);
  endtask

  task automatic t_reserved_from_direct;
    csr_write(32'h2000_00FE);
    check("R3 reserved 2 in direct", csr_rdata, 32'h2000_00FC);
  endtask

  task automatic t_vectored;
    csr_write(32'h8000_1235);
    check("R4 vectored align", csr_rdata, 32'h8000_1201);
    trap_check("R7 timer irq", 1'b1, 6'd5, 32'h8000_1214);
    trap_check("R7 irq cause 11", 1'b1, 6'd11, 32'h8000_122C);
    trap_check("R6 vec exc", 1'b0, 6'd5, 32'h8000_1200);
  endtask

  task automatic t_reserved_from_vectored;
    csr_write(32'h4000_0001);
    check("R2 vectored readback", csr_rdata, 32'h4000_0001);
    csr_write(32'h1234_567B);
    check("R3 reserved 3 in vectored", csr_rdata, 32'h1234_5641);
    trap_check("R7 max cause", 1'b1, 6'd63, 32'h1234_573C);
  endtask

  task automatic t_no_write;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = 32'hDEAD_BEE0;
    @(negedge clk);
    @(negedge clk);
    check("R9 no write", csr_rdata, 32'h1234_5641);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = 32'h0000_0100;
    trap = 1'b1; trap_irq = 1'b1; trap_cause = 6'd2;
    #1;
    check("R8 trap uses old csr", trap_pc, 32'h1234_5648);
    @(negedge clk);
    csr_we = 1'b0; trap = 1'b0;
    check("R8 write after trap", csr_rdata, 32'h0000_0100);
  endtask

  initial begin
    #20;
    @(negedge clk);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_direct();
    t_reserved_from_direct();
    t_vectored();
    t_reserved_from_vectored();
    t_no_write();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule